// File: doc/BRIEF.md
# Folded Symmetric FIR Delay-Line Router

This block is the sample-routing half of a symmetric FIR filter section for 12-bit two's complement video samples. Incoming samples travel down a forward chain of tap stages. At the far end they turn around into a reverse chain that runs back past the same taps. At every tap a registered pre-adder combines the forward sample (input A) with the reverse sample (input B). A downstream multiplier therefore needs only one coefficient per symmetric pair. With the default eight taps, one section serves a 16-tap symmetric filter, or a 15-tap filter when folded on an odd centre.

Each tap stage is a delay whose length can be set from 1 to 16 registers. This lets up to sixteen interleaved streams pass through one section without separating them, and it supports decimated operation. The turnaround point can be set for an even tap count, an odd tap count, or an odd tap count on interleaved data. The reverse chain can also take its data from a cascade input, so that several sections can be chained. A single active-high hold input freezes every delay register.

Top module: `fold_fir_router`

## Requirements
- R1: While `rst` is high, `casc_out` and every pre-adder field of `pre_out` read zero on the clock that follows, and every delay register clears.
- R2: Tap stage i delays by (code+1) accepted samples, where code is the 4-bit field `len_cfg[4i+3:4i]`. Code 0 gives 1 register and code 15 gives 16. With a uniform code, `casc_out` equals the sample accepted NTAP*(code+1) accepts earlier.
- R3: With `fold_sel`=0 (even fold) and `chain_end` high, the last forward stage output feeds the first reverse stage. Tap i then pairs the samples accepted (i+1)·L and (2·NTAP−i)·L accepts earlier, where L is the stage length.
- R4: With `fold_sel`=1 (odd fold), the reverse chain is fed the value that the last forward stage will present after the next accept. Tap i's reverse sample is then one accept younger than in R3, and the last tap sees the centre sample on both inputs.
- R5: With `fold_sel`=2 (odd interleaved fold), the input of the last forward stage feeds the reverse chain. Tap i's reverse sample is then L accepts younger than in R3.
- R6: Each pre-adder result is 13-bit two's complement and never wraps, including 2047+2047, (−2048)+(−2048) and −2048−2047.
- R7: With `sub_mode`=0 the pre-adder produces A+B. With `sub_mode`=1 it produces B−A.
- R8: With `pass_a` low, input A is forced to zero; with `pass_b` low, input B is forced to zero. Both inputs forced to zero gives a zero result.
- R9: While `hold` is high at a rising edge, no stage loads or shifts. `casc_out` keeps its value and the sample stream resumes without loss when `hold` falls.
- R10: With `chain_end` low, `casc_in` feeds the first reverse stage, so tap i's B input is the `casc_in` sample accepted (NTAP−i)·L accepts earlier.
- R11: `pre_out` tap i occupies bits [13i+12:13i] and is registered. It reflects the stage contents and the pre-adder controls one clock before.
- R12: `fold_sel`=3 behaves as the even fold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High freezes all delay stages |
| din | input | 12 | Forward chain sample input |
| len_cfg | input | NTAP*4 | Per-tap length code, tap i at [4i+3:4i] |
| fold_sel | input | 2 | 0 even, 1 odd, 2 odd interleaved, 3 even |
| chain_end | input | 1 | High: fold point feeds reverse chain; low: casc_in does |
| casc_in | input | 12 | Reverse chain input from a following section |
| sub_mode | input | 1 | 0: A+B, 1: B−A |
| pass_a | input | 1 | Low forces pre-adder input A to zero |
| pass_b | input | 1 | Low forces pre-adder input B to zero |
| casc_out | output | 12 | Last forward stage value |
| pre_out | output | NTAP*13 | Registered pre-adder results, tap i at [13i+12:13i] |

## Verification
The bench goes after the fold points with single impulses and random streams. A wrong even/odd/interleaved turnaround shifts the reverse samples by one or by L positions, which breaks the pairing at every tap and most visibly at the centre tap. Length codes 0 and 15 are both driven, so an off-by-one stage length shows up as a skewed `casc_out`. Saturated input runs at both extremes would wrap a 12-bit sum to the wrong sign. Hold bursts inside a running stream catch any stage that keeps shifting, because the sample count then drifts against the reference.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;
  typedef enum logic [1:0] {
    FOLD_EVEN = 2'd0,
    FOLD_ODD  = 2'd1,
    FOLD_ILV  = 2'd2,
    FOLD_RSV  = 2'd3
  } fold_e;
endpackage

// File: rtl/fold_delay_stage.sv
module fold_delay_stage #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic [DW-1:0] q_ahead
);
  logic [DEPTH-1:0][DW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (!hold) begin
      sr[0] <= d;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  // Output tap selected by the length code; q_ahead is what q becomes after the next shift.
  always_comb begin
    q       = sr[len];
    q_ahead = (len == '0) ? d : sr[len - LW'(1)];
  end

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(sr));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    !hold |=> sr[0] == $past(d));
endmodule

// File: rtl/fold_preadd.sv
module fold_preadd #(
  parameter int DW = 12,
  parameter int OW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic                 sub_mode,
  input  logic                 pass_a,
  input  logic                 pass_b,
  output logic signed [OW-1:0] y
);
  logic signed [OW-1:0] a_ext, b_ext, sum;

  always_comb begin
    a_ext = pass_a ? OW'(a) : '0;
    b_ext = pass_b ? OW'(b) : '0;
    sum   = sub_mode ? (b_ext - a_ext) : (a_ext + b_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else     y <= sum;
  end

  // R8
  gate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass_a && !pass_b) |=> y == '0);

  // R7
  sub_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_mode && pass_a && pass_b && (a == b)) |=> y == '0);
endmodule

// File: rtl/fold_turnaround.sv
module fold_turnaround
  import fold_fir_pkg::*;
#(
  parameter int DW = 12
) (
  input  fold_e         mode,
  input  logic          chain_end,
  input  logic [DW-1:0] last_q,
  input  logic [DW-1:0] last_ahead,
  input  logic [DW-1:0] last_in,
  input  logic [DW-1:0] casc_in,
  output logic [DW-1:0] rev_in
);
  always_comb begin
    if (!chain_end) begin
      rev_in = casc_in;
    end else begin
      unique case (mode)
        FOLD_ODD: rev_in = last_ahead;
        FOLD_ILV: rev_in = last_in;
        default:  rev_in = last_q;
      endcase
    end
  end
endmodule

// File: rtl/fold_fir_router.sv
module fold_fir_router
  import fold_fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int NTAP     = 8,
  parameter int MAX_LEN  = 16,
  parameter int LEN_W    = $clog2(MAX_LEN),
  parameter int SUM_W    = SAMPLE_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hold,
  input  logic [SAMPLE_W-1:0]   din,
  input  logic [NTAP*LEN_W-1:0] len_cfg,
  input  logic [1:0]            fold_sel,
  input  logic                  chain_end,
  input  logic [SAMPLE_W-1:0]   casc_in,
  input  logic                  sub_mode,
  input  logic                  pass_a,
  input  logic                  pass_b,
  output logic [SAMPLE_W-1:0]   casc_out,
  output logic [NTAP*SUM_W-1:0] pre_out
);
  logic [SAMPLE_W-1:0] fwd_in    [NTAP];
  logic [SAMPLE_W-1:0] fwd_q     [NTAP];
  logic [SAMPLE_W-1:0] fwd_ahead [NTAP];
  logic [SAMPLE_W-1:0] rev_in    [NTAP];
  logic [SAMPLE_W-1:0] rev_q     [NTAP];
  logic [SAMPLE_W-1:0] rev_ahead [NTAP];
  logic [SAMPLE_W-1:0] turn_val;

  fold_turnaround #(.DW(SAMPLE_W)) u_turn (
    .mode       (fold_e'(fold_sel)),
    .chain_end  (chain_end),
    .last_q     (fwd_q[NTAP-1]),
    .last_ahead (fwd_ahead[NTAP-1]),
    .last_in    (fwd_in[NTAP-1]),
    .casc_in    (casc_in),
    .rev_in     (turn_val)
  );

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (i == 0) begin : g_fhead
      assign fwd_in[i] = din;
    end else begin : g_fbody
      assign fwd_in[i] = fwd_q[i-1];
    end

    if (i == NTAP - 1) begin : g_rhead
      assign rev_in[i] = turn_val;
    end else begin : g_rbody
      assign rev_in[i] = rev_q[i+1];
    end

    fold_delay_stage #(.DW(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_fwd (
      .clk (clk), .rst (rst), .hold (hold),
      .len (len_cfg[i*LEN_W +: LEN_W]),
      .d   (fwd_in[i]), .q (fwd_q[i]), .q_ahead (fwd_ahead[i])
    );

    fold_delay_stage #(.DW(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_rev (
      .clk (clk), .rst (rst), .hold (hold),
      .len (len_cfg[i*LEN_W +: LEN_W]),
      .d   (rev_in[i]), .q (rev_q[i]), .q_ahead (rev_ahead[i])
    );

    fold_preadd #(.DW(SAMPLE_W), .OW(SUM_W)) u_add (
      .clk      (clk),
      .rst      (rst),
      .a        (fwd_q[i]),
      .b        (rev_q[i]),
      .sub_mode (sub_mode),
      .pass_a   (pass_a),
      .pass_b   (pass_b),
      .y        (pre_out[i*SUM_W +: SUM_W])
    );
  end

  assign casc_out = fwd_q[NTAP-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pre_out == '0) && (casc_out == '0));

  // R9
  casc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && $stable(len_cfg)) |=> $stable(casc_out));
endmodule

// File: tb/fold_fir_router_bench.sv
module fold_fir_router_bench;
  localparam int N  = 8;
  localparam int LW = 4;
  localparam int SW = 13;
  localparam int HD = 300;

  typedef struct packed {
    logic [1:0]  fold;
    logic [3:0]  code;
    logic        sub;
    logic        pa;
    logic        pb;
    logic        cend;
    logic        hold_en;
    logic [1:0]  pat;
    logic [15:0] cycles;
    logic [7:0]  req;
  } vec_t;

  localparam int ROWS = 15;
  localparam vec_t VECS [ROWS] = '{
    '{2'd0, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd60,  8'd3},  // R3 even, L=1
    '{2'd0, 4'd2,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd120, 8'd2},  // R2 length code 2
    '{2'd1, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 16'd60,  8'd4},  // R4 odd impulse
    '{2'd1, 4'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd100, 8'd4},  // R4 odd, L=2
    '{2'd2, 4'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd150, 8'd5},  // R5 interleaved odd
    '{2'd2, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 16'd60,  8'd5},  // R5 impulse
    '{2'd0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd300, 8'd2},  // R2 code 15
    '{2'd0, 4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd60,  8'd7},  // R7 B-A
    '{2'd3, 4'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 16'd80,  8'd12}, // R12 code 3
    '{2'd0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 16'd50,  8'd8},  // R8 A gated
    '{2'd0, 4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 16'd50,  8'd8},  // R8 B gated
    '{2'd0, 4'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 16'd150, 8'd6},  // R6 add extremes
    '{2'd0, 4'd1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 16'd150, 8'd6},  // R6 sub extremes
    '{2'd0, 4'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'd80,  8'd10}, // R10 cascade
    '{2'd1, 4'd2,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 16'd120, 8'd9}   // R9 hold bursts
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 hold = 1'b0;
  logic [11:0]          din = '0;
  logic [N*LW-1:0]      len_cfg = '0;
  logic [1:0]           fold_sel = '0;
  logic                 chain_end = 1'b1;
  logic [11:0]          casc_in = '0;
  logic                 sub_mode = 1'b0;
  logic                 pass_a = 1'b1;
  logic                 pass_b = 1'b1;
  logic [11:0]          casc_out;
  logic [N*SW-1:0]      pre_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic signed [11:0] hx [HD];
  logic signed [11:0] hc [HD];

  always #10 clk = ~clk;

  fold_fir_router u_fold_fir_router (
    .clk(clk), .rst(rst), .hold(hold), .din(din), .len_cfg(len_cfg),
    .fold_sel(fold_sel), .chain_end(chain_end), .casc_in(casc_in),
    .sub_mode(sub_mode), .pass_a(pass_a), .pass_b(pass_b),
    .casc_out(casc_out), .pre_out(pre_out)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog expired: actual=%0d cycles expected<=150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  function automatic logic signed [11:0] hget(input bit casc, input int d);
    if (d < 1 || d > HD) return '0;
    return casc ? hc[d-1] : hx[d-1];
  endfunction

  function automatic logic [11:0] pat_val(input int pat, input int cnt, input int seed);
    int t;
    case (pat)
      1: return ((cnt / 32) % 2 == 1) ? 12'h800 : 12'h7FF;
      2: return (cnt == 3) ? 12'd900 : 12'd0;
      default: begin
        t = cnt * 1103 + seed * 577 + cnt * cnt * 13;
        return t[11:0];
      end
    endcase
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < HD; k++) begin
      hx[k] = '0;
      hc[k] = '0;
    end
  endtask

  task automatic push_hist(input logic [11:0] x, input logic [11:0] c);
    for (int k = HD - 1; k > 0; k--) begin
      hx[k] = hx[k-1];
      hc[k] = hc[k-1];
    end
    hx[0] = x;
    hc[0] = c;
  endtask

  // R1: reset clears outputs
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    hold = 1'b0;
    repeat (2) @(negedge clk);
    check(casc_out == '0, 1, "casc_out after reset", int'(casc_out), 0);
    check(pre_out == '0, 1, "pre_out after reset", 0, 0);
    rst = 1'b0;
    clear_hist();
  endtask

  function automatic logic signed [12:0] tap_exp(input int i, input int fold, input int l,
      input bit sub, input bit pa, input bit pb, input bit cend);
    logic signed [12:0] a, b;
    int off;
    off = (fold == 1) ? 1 : (fold == 2) ? l : 0;
    a = pa ? 13'(hget(1'b0, (i + 1) * l)) : '0;
    if (!pb) b = '0;
    else if (cend) b = 13'(hget(1'b0, (2 * N - i) * l - off));
    else b = 13'(hget(1'b1, (N - i) * l));
    return sub ? (b - a) : (a + b);
  endfunction

  initial begin
    logic signed [12:0] exp_t [N];
    logic signed [12:0] got;
    logic [11:0] held;
    logic signed [31:0] mac_exp, mac_got;
    bit ok;
    int bad;
    clear_hist();
    do_reset();

    // Table walk: each row after a fresh reset.
    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      len_cfg   = {N{VECS[r].code}};
      fold_sel  = VECS[r].fold;
      sub_mode  = VECS[r].sub;
      pass_a    = VECS[r].pa;
      pass_b    = VECS[r].pb;
      chain_end = VECS[r].cend;
      for (int c = 0; c < int'(VECS[r].cycles); c++) begin
        din     = pat_val(int'(VECS[r].pat), c, r);
        casc_in = pat_val(0, c, r + 40);
        hold    = VECS[r].hold_en && (c % 5 == 2);
        for (int i = 0; i < N; i++)
          exp_t[i] = tap_exp(i, int'(VECS[r].fold), int'(VECS[r].code) + 1,
                             VECS[r].sub, VECS[r].pa, VECS[r].pb, VECS[r].cend);
        @(negedge clk);
        // R11: registered pre-adder results, one clock behind the stage state
        ok = 1'b1;
        bad = 0;
        for (int i = N - 1; i >= 0; i--) begin
          got = $signed(pre_out[i*SW +: SW]);
          if (got != exp_t[i]) begin
            ok = 1'b0;
            bad = i;
          end
        end
        got = $signed(pre_out[bad*SW +: SW]);
        check(ok, int'(VECS[r].req), $sformatf("row %0d cycle %0d tap %0d (R11 lane)", r, c, bad),
              int'(got), int'(exp_t[bad]));
        if (!hold) push_hist(din, casc_in);
        // R2: casc_out is din delayed by N*L accepts
        check(casc_out == hget(1'b0, N * (int'(VECS[r].code) + 1)), 2,
              $sformatf("casc_out row %0d cycle %0d", r, c),
              int'(casc_out), int'(hget(1'b0, N * (int'(VECS[r].code) + 1))));
      end
    end

    // R9 directed: a long hold keeps casc_out frozen.
    do_reset();
    len_cfg = {N{4'd0}}; fold_sel = 2'd0; chain_end = 1'b1;
    sub_mode = 1'b0; pass_a = 1'b1; pass_b = 1'b1;
    for (int c = 0; c < 20; c++) begin
      din = pat_val(0, c, 77);
      @(negedge clk);
    end
    held = casc_out;
    hold = 1'b1;
    for (int c = 0; c < 6; c++) begin
      din = pat_val(0, c, 99);
      @(negedge clk);
      check(casc_out == held, 9, "casc_out during hold", int'(casc_out), int'(held));
    end
    hold = 1'b0;

    // R3 directed: multiply-accumulate of the folded taps equals a direct 16-tap convolution.
    do_reset();
    for (int c = 0; c < 60; c++) begin
      din = pat_val(0, c, 5);
      mac_exp = 0;
      for (int k = 0; k < 2 * N; k++)
        mac_exp += 32'(((k < N) ? k : (2 * N - 1 - k)) + 1) * 32'(hget(1'b0, k + 1));
      @(negedge clk);
      mac_got = 0;
      for (int i = 0; i < N; i++)
        mac_got += 32'(i + 1) * 32'($signed(pre_out[i*SW +: SW]));
      check(mac_got == mac_exp, 3, $sformatf("MAC cycle %0d", c), mac_got, mac_exp);
      push_hist(din, casc_in);
    end

    // R1 final: reset from a busy state clears everything.
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule